// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block tracks in-flight loads of an out-of-order core in a circular queue. Each load takes the entry at the tail in program order and keeps its sequence number. Once it executes, the entry also holds its effective address and an executed flag. When a load is allocated, the block returns the queue slot it was given and the store-queue position that was current at that moment. A store later uses that position to bound its ordering check.

When a store executes, it supplies the load-queue position it captured at its own allocation. The block walks forward from that position to the current tail. It looks for an executed load whose address falls in the same 256-byte block as the store's address. The first such load in program order is latched as the ordering violator and a fault pulse is raised. While a violator waits to be read, later store checks are skipped. Reading the violator clears it.

Loads leave the queue in two ways. Commit retires head entries whose sequence number is not younger than a given value. Squash rolls the tail back over every trailing entry younger than a given value. Both act on any number of entries in one cycle. The queue keeps one physical slot more than its usable depth, and it reports whether it is full and how many entries are free.

Top module: `load_order_queue`

## Requirements
- R1: After reset the queue is empty: lq_free equals LQ_DEPTH, lq_full is 0, lq_head and lq_tail are 0, no violator is pending and no fault, ack or count is raised.
- R2: An accepted allocation raises alloc_ack in the next cycle with alloc_lq_idx equal to the tail before the allocation. The tail then advances by one and lq_free drops by one.
- R3: With LQ_DEPTH entries held, lq_full is 1 and lq_free is 0. A further allocation is refused: no alloc_ack follows and lq_tail is unchanged.
- R4: On each accepted allocation, alloc_sq_none is 1 when alloc_sq_empty was 1; in that case alloc_sq_idx is 0. Otherwise alloc_sq_none is 0 and alloc_sq_idx equals the alloc_sq_tail that was given.
- R5: Head and tail indices run over LQ_DEPTH+1 physical slots. Advancing from the last slot gives 0, and stepping back from 0 gives the last slot.
- R6: With retire_valid, entries are removed from the head for as long as the queue is non-empty and the head sequence number is at most retire_seq. retired_n reports the number removed, and removal stops at the first younger entry.
- R7: With kill_valid, entries are removed backwards from the entry just before the tail while their sequence number is strictly greater than kill_seq. killed_n reports the number removed. A kill in the same cycle as a retire or an allocation overrides both, and they have no effect.
- R8: A store check scans the slots from st_lq_start up to, but not including, the tail. It matches the first executed load whose address bits above bit 7 equal those of st_addr. A match raises st_fault for one cycle and latches viol_pending, viol_idx and the load's sequence number in viol_seq.
- R9: Loads that have not executed, and slots outside the scan window, never cause a match.
- R10: While viol_pending is 1, store checks are skipped: st_fault stays 0 and viol_idx and viol_seq hold. viol_rd clears viol_pending in the next cycle.
- R11: All results appear one clock after the stimulus that causes them, and all are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_empty | input | 1 | Store queue holds no stores |
| alloc_sq_tail | input | SQ_IDX_W | Current store-queue tail |
| exec_valid | input | 1 | A load has executed |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address of the executed load |
| st_valid | input | 1 | A store executes; run the ordering check |
| st_lq_start | input | IDX_W | Load-queue position captured by the store |
| st_addr | input | ADDR_W | Store effective address |
| viol_rd | input | 1 | Read and clear the latched violator |
| retire_valid | input | 1 | Commit loads up to retire_seq |
| retire_seq | input | SEQ_W | Youngest committed sequence number |
| kill_valid | input | 1 | Squash loads younger than kill_seq |
| kill_seq | input | SEQ_W | Squash boundary sequence number |
| alloc_ack | output | 1 | Allocation was accepted |
| alloc_lq_idx | output | IDX_W | Slot given to the accepted load |
| alloc_sq_none | output | 1 | Recorded store index is "none" |
| alloc_sq_idx | output | SQ_IDX_W | Recorded store-queue index |
| lq_full | output | 1 | Queue holds LQ_DEPTH entries |
| lq_free | output | IDX_W | Free usable entries |
| lq_head | output | IDX_W | Head slot |
| lq_tail | output | IDX_W | Tail slot |
| retired_n | output | IDX_W | Entries retired by the last commit |
| killed_n | output | IDX_W | Entries removed by the last squash |
| st_fault | output | 1 | The last store check found a violation |
| viol_pending | output | 1 | A violator is latched and unread |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |

## Verification
Every result of this block is due exactly one clock after the cycle that drives its stimulus. This covers the allocation acknowledgement, the retire and squash counts, the fault pulse, the latched violator, the pointers and the free count. The bench drives each stimulus on a falling edge and, in the same step, works out the expected outputs from its own model of the queue. It pushes them to a scoreboard and waits one cycle. The monitor pops and compares one item a short delay after the following rising edge, so each comparison lands on the cycle in which the registered result first becomes visible.

// File: rtl/loq_pkg.sv
package loq_pkg;

  // Wrap-around add and subtract over a ring of n slots, for a, b < n.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? (s - n) : s;
  endfunction

  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned n);
    return (a >= b) ? (a - b) : (a + n - b);
  endfunction

endpackage

// File: rtl/loq_entry_file.sv
module loq_entry_file #(
  parameter int NPHYS  = 9,
  parameter int IDX_W  = 4,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_we,
  input  logic [IDX_W-1:0]              alloc_idx,
  input  logic [SEQ_W-1:0]              alloc_seq,
  input  logic                          exec_we,
  input  logic [IDX_W-1:0]              exec_idx,
  input  logic [ADDR_W-1:0]             exec_addr,
  output logic [NPHYS-1:0][SEQ_W-1:0]   seq_vec,
  output logic [NPHYS-1:0][ADDR_W-1:0]  addr_vec,
  output logic [NPHYS-1:0]              done_vec
);

  // Payload registers: no reset, written by index only.
  always_ff @(posedge clk) begin
    if (alloc_we) seq_vec[alloc_idx] <= alloc_seq;
    if (exec_we)  addr_vec[exec_idx] <= exec_addr;
  end

  // Executed flags: a fresh entry starts unexecuted, which keeps it out of
  // every store check until its address is known.
  genvar i;
  generate
    for (i = 0; i < NPHYS; i++) begin : g_done
      always_ff @(posedge clk) begin
        if (rst) begin
          done_vec[i] <= 1'b0;
        end else if (alloc_we && alloc_idx == IDX_W'(i)) begin
          done_vec[i] <= 1'b0;
        end else if (exec_we && exec_idx == IDX_W'(i)) begin
          done_vec[i] <= 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/loq_run_len.sv
module loq_run_len #(
  parameter int NPHYS    = 9,
  parameter int IDX_W    = 4,
  parameter bit BACKWARD = 1'b0
) (
  input  logic [IDX_W-1:0] start,
  input  logic [IDX_W-1:0] limit,
  input  logic [NPHYS-1:0] pred,
  output logic [IDX_W-1:0] run
);
  import loq_pkg::*;

  logic [IDX_W-1:0] slot_of [NPHYS];
  logic [NPHYS-1:0] elig;

  genvar k;
  generate
    for (k = 0; k < NPHYS; k++) begin : g_slot
      if (BACKWARD) begin : g_bwd
        assign slot_of[k] = IDX_W'(ring_sub(32'(start), k, NPHYS));
      end else begin : g_fwd
        assign slot_of[k] = IDX_W'(ring_add(32'(start), k, NPHYS));
      end
      assign elig[k] = (IDX_W'(k) < limit) && pred[slot_of[k]];
    end
  endgenerate

  // Count of leading eligible slots in walk order.
  always_comb begin
    logic stop;
    run  = '0;
    stop = 1'b0;
    for (int j = 0; j < NPHYS; j++) begin
      if (!stop && elig[j]) run = run + IDX_W'(1);
      else                  stop = 1'b1;
    end
  end

endmodule

// File: rtl/loq_viol_scan.sv
module loq_viol_scan #(
  parameter int NPHYS     = 9,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic [IDX_W-1:0]              start,
  input  logic [IDX_W-1:0]              tail,
  input  logic [NPHYS-1:0]              done_vec,
  input  logic [NPHYS-1:0][ADDR_W-1:0]  addr_vec,
  input  logic [ADDR_W-1:0]             st_addr,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  import loq_pkg::*;

  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [IDX_W-1:0] win_len;
  logic [IDX_W-1:0] slot_of [NPHYS];
  logic [NPHYS-1:0] slot_match;
  logic [NPHYS-1:0] cand;

  assign win_len = IDX_W'(ring_sub(32'(tail), 32'(start), NPHYS));

  genvar i;
  generate
    for (i = 0; i < NPHYS; i++) begin : g_cmp
      assign slot_match[i] = done_vec[i] &&
        (addr_vec[i][ADDR_W-1:BLK_SHIFT] == st_addr[ADDR_W-1:BLK_SHIFT]);
      assign slot_of[i] = IDX_W'(ring_add(32'(start), i, NPHYS));
      assign cand[i]    = (IDX_W'(i) < win_len) && slot_match[slot_of[i]];
    end
  endgenerate

  // Oldest candidate in program order, counted from the store's position.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < NPHYS; k++) begin
      if (!hit && cand[k]) begin
        hit     = 1'b1;
        hit_idx = slot_of[k];
      end
    end
  end

  logic [BLK_W-1:0] unused_blk;
  assign unused_blk = '0;

endmodule

// File: rtl/load_order_queue.sv
module load_order_queue #(
  parameter int LQ_DEPTH  = 8,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int SQ_IDX_W  = 4,
  parameter int BLK_SHIFT = 8,
  localparam int NPHYS    = LQ_DEPTH + 1,
  localparam int IDX_W    = $clog2(NPHYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_valid,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic                alloc_sq_empty,
  input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
  input  logic                exec_valid,
  input  logic [IDX_W-1:0]    exec_idx,
  input  logic [ADDR_W-1:0]   exec_addr,
  input  logic                st_valid,
  input  logic [IDX_W-1:0]    st_lq_start,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                viol_rd,
  input  logic                retire_valid,
  input  logic [SEQ_W-1:0]    retire_seq,
  input  logic                kill_valid,
  input  logic [SEQ_W-1:0]    kill_seq,
  output logic                alloc_ack,
  output logic [IDX_W-1:0]    alloc_lq_idx,
  output logic                alloc_sq_none,
  output logic [SQ_IDX_W-1:0] alloc_sq_idx,
  output logic                lq_full,
  output logic [IDX_W-1:0]    lq_free,
  output logic [IDX_W-1:0]    lq_head,
  output logic [IDX_W-1:0]    lq_tail,
  output logic [IDX_W-1:0]    retired_n,
  output logic [IDX_W-1:0]    killed_n,
  output logic                st_fault,
  output logic                viol_pending,
  output logic [IDX_W-1:0]    viol_idx,
  output logic [SEQ_W-1:0]    viol_seq
);
  import loq_pkg::*;

  localparam logic [IDX_W-1:0] DEPTH_C = IDX_W'(LQ_DEPTH);

  logic [IDX_W-1:0] occ_q;
  logic [IDX_W-1:0] head_n, tail_n, occ_n;
  logic             alloc_go;
  logic             scan_go;

  logic [NPHYS-1:0][SEQ_W-1:0]  seq_vec;
  logic [NPHYS-1:0][ADDR_W-1:0] addr_vec;
  logic [NPHYS-1:0]             done_vec;

  // Squash outranks both commit and allocation in the same cycle.
  assign alloc_go = alloc_valid && !kill_valid && (occ_q != DEPTH_C);

  loq_entry_file #(
    .NPHYS(NPHYS), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
  ) u_entries (
    .clk       (clk),
    .rst       (rst),
    .alloc_we  (alloc_go),
    .alloc_idx (lq_tail),
    .alloc_seq (alloc_seq),
    .exec_we   (exec_valid),
    .exec_idx  (exec_idx),
    .exec_addr (exec_addr),
    .seq_vec   (seq_vec),
    .addr_vec  (addr_vec),
    .done_vec  (done_vec)
  );

  // Per-slot age tests feeding the two run counters.
  logic [NPHYS-1:0] old_enough;
  logic [NPHYS-1:0] too_young;
  genvar i;
  generate
    for (i = 0; i < NPHYS; i++) begin : g_age
      assign old_enough[i] = (seq_vec[i] <= retire_seq);
      assign too_young[i]  = (seq_vec[i] >  kill_seq);
    end
  endgenerate

  logic [IDX_W-1:0] n_ret, n_kill, kill_start;
  assign kill_start = IDX_W'(ring_sub(32'(lq_tail), 1, NPHYS));

  loq_run_len #(.NPHYS(NPHYS), .IDX_W(IDX_W), .BACKWARD(1'b0)) u_commit_run (
    .start (lq_head),
    .limit (occ_q),
    .pred  (old_enough),
    .run   (n_ret)
  );

  loq_run_len #(.NPHYS(NPHYS), .IDX_W(IDX_W), .BACKWARD(1'b1)) u_squash_run (
    .start (kill_start),
    .limit (occ_q),
    .pred  (too_young),
    .run   (n_kill)
  );

  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;

  loq_viol_scan #(
    .NPHYS(NPHYS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
  ) u_scan (
    .start    (st_lq_start),
    .tail     (lq_tail),
    .done_vec (done_vec),
    .addr_vec (addr_vec),
    .st_addr  (st_addr),
    .hit      (scan_hit),
    .hit_idx  (scan_idx)
  );

  assign scan_go = st_valid && !viol_pending && scan_hit;

  // Next pointer and occupancy state.
  always_comb begin
    head_n = lq_head;
    tail_n = lq_tail;
    occ_n  = occ_q;
    if (kill_valid) begin
      tail_n = IDX_W'(ring_sub(32'(lq_tail), 32'(n_kill), NPHYS));
      occ_n  = occ_q - n_kill;
    end else begin
      if (retire_valid) begin
        head_n = IDX_W'(ring_add(32'(lq_head), 32'(n_ret), NPHYS));
        occ_n  = occ_q - n_ret;
      end
      if (alloc_go) begin
        tail_n = IDX_W'(ring_add(32'(lq_tail), 1, NPHYS));
        occ_n  = occ_n + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lq_head       <= '0;
      lq_tail       <= '0;
      occ_q         <= '0;
      lq_full       <= 1'b0;
      lq_free       <= DEPTH_C;
      alloc_ack     <= 1'b0;
      alloc_lq_idx  <= '0;
      alloc_sq_none <= 1'b0;
      alloc_sq_idx  <= '0;
      retired_n     <= '0;
      killed_n      <= '0;
      st_fault      <= 1'b0;
      viol_pending  <= 1'b0;
      viol_idx      <= '0;
      viol_seq      <= '0;
    end else begin
      lq_head   <= head_n;
      lq_tail   <= tail_n;
      occ_q     <= occ_n;
      lq_full   <= (occ_n == DEPTH_C);
      lq_free   <= DEPTH_C - occ_n;
      alloc_ack <= alloc_go;
      if (alloc_go) begin
        alloc_lq_idx  <= lq_tail;
        alloc_sq_none <= alloc_sq_empty;
        alloc_sq_idx  <= alloc_sq_empty ? '0 : alloc_sq_tail;
      end
      retired_n <= (retire_valid && !kill_valid) ? n_ret : '0;
      killed_n  <= kill_valid ? n_kill : '0;
      st_fault  <= scan_go;
      if (viol_rd) viol_pending <= 1'b0;
      if (scan_go) begin
        viol_pending <= 1'b1;
        viol_idx     <= scan_idx;
        viol_seq     <= seq_vec[scan_idx];
      end
    end
  end

endmodule

// File: rtl/loq_checker.sv
module loq_checker #(
  parameter int LQ_DEPTH = 8,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             st_valid,
  input logic             viol_rd,
  input logic             retire_valid,
  input logic             kill_valid,
  input logic             alloc_ack,
  input logic [IDX_W-1:0] alloc_lq_idx,
  input logic             lq_full,
  input logic [IDX_W-1:0] lq_tail,
  input logic [IDX_W-1:0] retired_n,
  input logic             st_fault,
  input logic             viol_pending,
  input logic [IDX_W-1:0] viol_idx,
  input logic [SEQ_W-1:0] viol_seq
);

  a_r2_alloc_slot: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !lq_full && !kill_valid) |=> (alloc_ack && alloc_lq_idx == $past(lq_tail)));

  a_r3_refuse_full: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && lq_full) |=> !alloc_ack);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (lq_full && !retire_valid && !kill_valid) |=> (lq_full && $stable(lq_tail)));

  a_r7_kill_wins: assert property (@(posedge clk) disable iff (rst)
    kill_valid |=> (retired_n == '0 && !alloc_ack));

  a_r8_fault_latches: assert property (@(posedge clk) disable iff (rst)
    st_fault |-> (viol_pending && $past(st_valid)));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    viol_pending |=> !st_fault);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (viol_pending && !viol_rd) |=> (viol_pending && $stable(viol_idx) && $stable(viol_seq)));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    viol_rd |=> !viol_pending || st_fault);

endmodule

bind load_order_queue loq_checker #(
  .LQ_DEPTH (LQ_DEPTH),
  .SEQ_W    (SEQ_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .st_valid     (st_valid),
  .viol_rd      (viol_rd),
  .retire_valid (retire_valid),
  .kill_valid   (kill_valid),
  .alloc_ack    (alloc_ack),
  .alloc_lq_idx (alloc_lq_idx),
  .lq_full      (lq_full),
  .lq_tail      (lq_tail),
  .retired_n    (retired_n),
  .st_fault     (st_fault),
  .viol_pending (viol_pending),
  .viol_idx     (viol_idx),
  .viol_seq     (viol_seq)
);

// File: tb/load_order_queue_tb.sv
`timescale 1ns/1ps
module load_order_queue_tb;
  localparam int DEPTH = 8;
  localparam int NP    = DEPTH + 1;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        alloc_valid = 0, alloc_sq_empty = 0, exec_valid = 0, st_valid = 0;
  logic        viol_rd = 0, retire_valid = 0, kill_valid = 0;
  logic [15:0] alloc_seq = 0, retire_seq = 0, kill_seq = 0;
  logic [3:0]  alloc_sq_tail = 0;
  logic [IW-1:0] exec_idx = 0, st_lq_start = 0;
  logic [31:0] exec_addr = 0, st_addr = 0;

  logic alloc_ack, alloc_sq_none, lq_full, st_fault, viol_pending;
  logic [IW-1:0] alloc_lq_idx, lq_free, lq_head, lq_tail, retired_n, killed_n, viol_idx;
  logic [3:0]  alloc_sq_idx;
  logic [15:0] viol_seq;

  load_order_queue u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_sq_empty(alloc_sq_empty),
    .alloc_sq_tail(alloc_sq_tail), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_addr(exec_addr), .st_valid(st_valid), .st_lq_start(st_lq_start),
    .st_addr(st_addr), .viol_rd(viol_rd), .retire_valid(retire_valid),
    .retire_seq(retire_seq), .kill_valid(kill_valid), .kill_seq(kill_seq),
    .alloc_ack(alloc_ack), .alloc_lq_idx(alloc_lq_idx), .alloc_sq_none(alloc_sq_none),
    .alloc_sq_idx(alloc_sq_idx), .lq_full(lq_full), .lq_free(lq_free),
    .lq_head(lq_head), .lq_tail(lq_tail), .retired_n(retired_n), .killed_n(killed_n),
    .st_fault(st_fault), .viol_pending(viol_pending), .viol_idx(viol_idx),
    .viol_seq(viol_seq)
  );

  typedef struct {
    string tag;
    bit ack; int idx; bit sqnone; int sqidx;
    bit full; int free; int head; int tail; int ret; int kill;
    bit fault; bit pend; int vidx; int vseq;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model of the queue.
  int  m_seq [NP];
  int  m_addr[NP];
  bit  m_done[NP];
  int  mh = 0, mt = 0, mc = 0;
  bit  mpend = 0;
  int  mvidx = 0, mvseq = 0;

  task automatic tick(input string tag);
    exp_t e;
    bit hit; int hs; int len; int s; bit go;
    e.tag = tag; e.ret = 0; e.kill = 0; e.ack = 0; e.idx = 0;
    hit = 0; hs = 0;
    len = (mt - int'(st_lq_start) + NP) % NP;
    for (int k = 0; k < len; k++) begin
      s = (int'(st_lq_start) + k) % NP;
      if (!hit && m_done[s] && (m_addr[s] >>> 8) == (int'(st_addr) >>> 8)) begin
        hit = 1; hs = s;
      end
    end
    e.fault = st_valid && !mpend && hit;
    if (viol_rd) mpend = 0;
    if (e.fault) begin mpend = 1; mvidx = hs; mvseq = m_seq[hs]; end
    if (kill_valid) begin
      s = (mt - 1 + NP) % NP;
      while (mc > 0 && m_seq[s] > int'(kill_seq)) begin
        mc--; e.kill++; mt = s; s = (s - 1 + NP) % NP;
      end
    end else begin
      go = alloc_valid && (mc < DEPTH);
      if (retire_valid)
        while (mc > 0 && m_seq[mh] <= int'(retire_seq)) begin
          mc--; e.ret++; mh = (mh + 1) % NP;
        end
      if (go) begin
        e.ack = 1; e.idx = mt;
        m_seq[mt] = int'(alloc_seq); m_done[mt] = 0;
        mt = (mt + 1) % NP; mc++;
      end
    end
    if (exec_valid) begin m_addr[exec_idx] = int'(exec_addr); m_done[exec_idx] = 1; end
    e.sqnone = alloc_sq_empty; e.sqidx = alloc_sq_empty ? 0 : int'(alloc_sq_tail);
    e.full = (mc == DEPTH); e.free = DEPTH - mc; e.head = mh; e.tail = mt;
    e.pend = mpend; e.vidx = mvidx; e.vseq = mvseq;
    sb.push_back(e);
    @(negedge clk);
    alloc_valid = 0; exec_valid = 0; st_valid = 0; viol_rd = 0;
    retire_valid = 0; kill_valid = 0; alloc_sq_empty = 0;
  endtask

  // Scoreboard monitor: results are due one cycle after each tick.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e; bit ok;
      e = sb.pop_front();
      ok = (alloc_ack == e.ack) && (lq_full == e.full) && (int'(lq_free) == e.free) &&
           (int'(lq_head) == e.head) && (int'(lq_tail) == e.tail) &&
           (int'(retired_n) == e.ret) && (int'(killed_n) == e.kill) &&
           (st_fault == e.fault) && (viol_pending == e.pend);
      if (e.ack) ok = ok && (int'(alloc_lq_idx) == e.idx) &&
                      (alloc_sq_none == e.sqnone) && (int'(alloc_sq_idx) == e.sqidx);
      if (e.pend) ok = ok && (int'(viol_idx) == e.vidx) && (int'(viol_seq) == e.vseq);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s: got ack=%0d idx=%0d sqn=%0d sqi=%0d full=%0d free=%0d h=%0d t=%0d ret=%0d kill=%0d flt=%0d pend=%0d vi=%0d vs=%0d",
          e.tag, alloc_ack, alloc_lq_idx, alloc_sq_none, alloc_sq_idx, lq_full, lq_free,
          lq_head, lq_tail, retired_n, killed_n, st_fault, viol_pending, viol_idx, viol_seq);
        $display("     %s: exp ack=%0d idx=%0d sqn=%0d sqi=%0d full=%0d free=%0d h=%0d t=%0d ret=%0d kill=%0d flt=%0d pend=%0d vi=%0d vs=%0d",
          e.tag, e.ack, e.idx, e.sqnone, e.sqidx, e.full, e.free, e.head, e.tail,
          e.ret, e.kill, e.fault, e.pend, e.vidx, e.vseq);
      end
    end
  end

  task automatic do_alloc(input int seq, input bit sq_empty, input int sqt, input string tag);
    alloc_valid = 1; alloc_seq = 16'(seq); alloc_sq_empty = sq_empty; alloc_sq_tail = 4'(sqt);
    tick(tag);
  endtask

  task automatic do_exec(input int idx, input int addr, input string tag);
    exec_valid = 1; exec_idx = IW'(idx); exec_addr = 32'(addr);
    tick(tag);
  endtask

  task automatic do_store(input int start, input int addr, input string tag);
    st_valid = 1; st_lq_start = IW'(start); st_addr = 32'(addr);
    tick(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick("R1");                                   // reset state
    do_alloc(10, 1, 0, "R4");                     // sq empty -> none
    do_alloc(11, 0, 5, "R2");
    do_alloc(12, 0, 6, "R4");
    do_exec(0, 'h1234, "R2");
    do_exec(1, 'h5600, "R2");
    do_store(0, 'h12FF, "R8");                    // hits slot 0
    do_store(1, 'h5611, "R10");                   // skipped while pending
    viol_rd = 1; tick("R10");
    do_store(1, 'h1200, "R9");                    // slot 0 outside window, slot 2 unexecuted
    do_exec(2, 'h1280, "R9");
    do_store(1, 'h12AA, "R8");                    // hits slot 2
    viol_rd = 1; tick("R10");
    retire_valid = 1; retire_seq = 11; tick("R6"); // retires 10,11, stops at 12
    for (int i = 0; i < 7; i++) do_alloc(20 + i, 0, 1, "R5");
    do_alloc(40, 0, 2, "R3");                     // refused when full
    kill_valid = 1; kill_seq = 23; alloc_valid = 1; alloc_seq = 50; tick("R7");
    kill_valid = 1; kill_seq = 100; retire_valid = 1; retire_seq = 30; tick("R7");
    retire_valid = 1; retire_seq = 21; tick("R6");
    do_alloc(30, 0, 3, "R5");
    do_alloc(31, 0, 3, "R5");
    do_alloc(32, 0, 3, "R5");                     // tail wraps to slot 0 then 1
    do_exec(8, 'h7700, "R8");
    do_exec(0, 'h7701, "R8");
    do_exec(6, 'h7702, "R8");
    do_store(7, 'h77FF, "R8");                    // window 7,8,0: first is slot 8
    viol_rd = 1; tick("R10");
    kill_valid = 1; kill_seq = 22; tick("R7");    // wraps tail back over slot 0
    tick("R11");
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule